// File: doc/BRIEF.md
# Dual-Half Interval Timer

This peripheral holds two 32-bit up-counters, a lower half and an upper half, behind a small 32-bit register bus. Each half has a count register that software can read and write, and a period register. One shared control word holds a 2-bit enable field for each half: off, single-shot or repeating. A global control word holds a mode field and one reset-release bit per half. An unreleased half stays at zero. Each half drives its own one-cycle event pulse when its count reaches its period.

The mode field decides how the halves work together. With mode 0 the two halves form one 64-bit counter. The upper half advances only when the lower half rolls over. The period compare uses all 64 bits. The lower half's enable field controls the pair. With any other mode value the halves run separately as two 32-bit timers. A typical use keeps one half repeating as a free-running time base and uses the other half for single timeouts.

Top module: `dual_half_timer`

## Requirements
- R1: After a synchronous reset every writable register reads 0, both event outputs are low, and the identity word at byte offset 0x00 reads 32'h7D4E_0001.
- R2: Byte offsets are: lower count 0x10, upper count 0x14, lower period 0x18, upper period 0x1C, control 0x20, global control 0x24. A read strobe returns the addressed word on `bus_rdata` one clock later.
- R3: The lower half's enable field is control bits [7:6] and the upper half's field is bits [23:22]. Value 0 is off, 1 is single-shot and 2 is repeating. Value 3 is stored and read back, but the half does not count.
- R4: Global control bit 0 releases the lower half and bit 1 releases the upper half. While its bit is 0 a half holds count 0, ignores count writes and raises no event.
- R5: A count write to a half that is off takes effect on the next clock, zero included, and the value then stays unchanged.
- R6: In repeating mode a running half adds one each clock. In the cycle where the count equals the period, the count goes to 0 on the next edge and the event output is high for that next cycle. Pulses therefore repeat every period+1 clocks.
- R7: In single-shot mode the half pulses once, its count returns to 0, and its enable field clears to 0.
- R8: With global mode bits [3:2] nonzero, the two halves run independently, each with its own period and event.
- R9: With global mode 0 the halves form one 64-bit counter. It needs both release bits and is enabled by the lower field. The upper half advances only when the lower half rolls over from all ones, the period compare covers all 64 bits, and only the lower event output pulses.
- R10: Reserved control and global-control bits read 0. Offset 0x28 and unused offsets read 0, and writes to them have no effect.
- R11: A bus write that lands in the same cycle as a period match wins. A count write loads the written value instead of 0, and a control write replaces the single-shot clear. The event pulse is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| evt_lo | output | 1 | Lower-half (or 64-bit) event pulse |
| evt_hi | output | 1 | Upper-half event pulse |

## Verification
Two things can fall in the same clock: a software write to a count or control register, and the match that would reset that count or clear a single-shot enable. The bench starts a half from a known count and counts edges so that its write lands exactly on the match edge. For a count write it checks two things: the event still pulses, and the count continues from the written value, shown by a readback one edge later. For a control write during a single-shot finish it checks that the written repeating mode survives and that a second pulse follows period+1 clocks later.

// File: rtl/dht_pkg.sv
package dht_pkg;
  localparam logic [7:0] OFF_ID     = 8'h00;
  localparam logic [7:0] OFF_CNT_LO = 8'h10;
  localparam logic [7:0] OFF_CNT_HI = 8'h14;
  localparam logic [7:0] OFF_PRD_LO = 8'h18;
  localparam logic [7:0] OFF_PRD_HI = 8'h1C;
  localparam logic [7:0] OFF_CTRL   = 8'h20;
  localparam logic [7:0] OFF_GCTRL  = 8'h24;

  localparam logic [31:0] TIMER_ID  = 32'h7D4E_0001;

  // enable field encoding
  localparam logic [1:0] EN_OFF    = 2'd0;
  localparam logic [1:0] EN_ONCE   = 2'd1;
  localparam logic [1:0] EN_REPEAT = 2'd2;

  // global mode: only value 0 links the halves
  localparam logic [1:0] GM_LINK64 = 2'd0;

  function automatic logic en_runs(input logic [1:0] f);
    return (f == EN_ONCE) || (f == EN_REPEAT);
  endfunction
endpackage

// File: rtl/dht_half.sv
module dht_half #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  input  logic          wrap,
  input  logic [DW-1:0] prd,
  output logic [DW-1:0] cnt,
  output logic          eq
);
  logic [DW-1:0] cnt_q;

  // priority: reset, held, bus write, wrap, step
  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q <= '0;
    end else if (wr) begin
      cnt_q <= wdata;
    end else if (wrap) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + DW'(1);
    end
  end

  assign cnt = cnt_q;
  assign eq  = (cnt_q == prd);
endmodule

// File: rtl/dht_seq.sv
module dht_seq
  import dht_pkg::*;
#(
  parameter int DW = 32,
  parameter int NH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          gmode,
  input  logic [NH-1:0][1:0]  en,
  input  logic [NH-1:0]       rel,
  input  logic [NH-1:0]       eq,
  input  logic [DW-1:0]       cnt_lo,
  output logic [NH-1:0]       hold,
  output logic [NH-1:0]       step,
  output logic [NH-1:0]       wrap,
  output logic [NH-1:0]       hit,
  output logic [NH-1:0]       evt
);
  logic linked;
  logic lo_full;
  logic pair_run;
  logic pair_hit;

  assign linked   = (gmode == GM_LINK64);
  assign lo_full  = &cnt_lo;
  assign pair_run = en_runs(en[0]) && (&rel);
  assign pair_hit = pair_run && (&eq);
  assign hold     = ~rel;

  always_comb begin
    step = '0;
    wrap = '0;
    hit  = '0;
    if (linked) begin
      step[0] = pair_run && !pair_hit;
      wrap[0] = pair_hit;
      step[1] = pair_run && !pair_hit && lo_full;
      wrap[1] = pair_hit;
      hit[0]  = pair_hit;
    end else begin
      for (int h = 0; h < NH; h++) begin
        step[h] = en_runs(en[h]) && rel[h] && !eq[h];
        wrap[h] = en_runs(en[h]) && rel[h] && eq[h];
        hit[h]  = en_runs(en[h]) && rel[h] && eq[h];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt <= '0;
    else     evt <= hit;
  end
endmodule

// File: rtl/dht_regs.sv
module dht_regs
  import dht_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int NH     = 2,
  parameter int LO_POS = 6,
  parameter int HI_POS = 22
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  input  logic [NH-1:0][DW-1:0] cnt,
  input  logic [NH-1:0]         done,
  output logic [DW-1:0]         bus_rdata,
  output logic [NH-1:0][1:0]    en,
  output logic [1:0]            gmode,
  output logic [NH-1:0]         rel,
  output logic [NH-1:0][DW-1:0] prd,
  output logic [NH-1:0]         wr_cnt
);
  logic [NH-1:0][1:0]    en_q;
  logic [1:0]            gm_q;
  logic [NH-1:0]         rel_q;
  logic [NH-1:0][DW-1:0] prd_q;
  logic                  wr_ctrl;
  logic                  wr_gctrl;
  logic [NH-1:0]         wr_prd;
  logic [DW-1:0]         ctrl_word;
  logic [DW-1:0]         gctrl_word;

  assign wr_ctrl   = bus_wr && (bus_addr == AW'(OFF_CTRL));
  assign wr_gctrl  = bus_wr && (bus_addr == AW'(OFF_GCTRL));
  assign wr_cnt[0] = bus_wr && (bus_addr == AW'(OFF_CNT_LO));
  assign wr_cnt[1] = bus_wr && (bus_addr == AW'(OFF_CNT_HI));
  assign wr_prd[0] = bus_wr && (bus_addr == AW'(OFF_PRD_LO));
  assign wr_prd[1] = bus_wr && (bus_addr == AW'(OFF_PRD_HI));

  always_comb begin
    ctrl_word = '0;
    ctrl_word[LO_POS +: 2] = en_q[0];
    ctrl_word[HI_POS +: 2] = en_q[1];
    gctrl_word = '0;
    gctrl_word[3:2] = gm_q;
    gctrl_word[1:0] = rel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_ctrl) begin
      en_q[0] <= bus_wdata[LO_POS +: 2];
      en_q[1] <= bus_wdata[HI_POS +: 2];
    end else begin
      for (int h = 0; h < NH; h++) begin
        if (done[h] && en_q[h] == EN_ONCE) en_q[h] <= EN_OFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gm_q  <= '0;
      rel_q <= '0;
    end else if (wr_gctrl) begin
      gm_q  <= bus_wdata[3:2];
      rel_q <= bus_wdata[1:0];
    end
  end

  generate
    for (genvar h = 0; h < NH; h++) begin : g_prd
      always_ff @(posedge clk) begin
        if (rst)            prd_q[h] <= '0;
        else if (wr_prd[h]) prd_q[h] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        AW'(OFF_ID):     bus_rdata <= DW'(TIMER_ID);
        AW'(OFF_CNT_LO): bus_rdata <= cnt[0];
        AW'(OFF_CNT_HI): bus_rdata <= cnt[1];
        AW'(OFF_PRD_LO): bus_rdata <= prd_q[0];
        AW'(OFF_PRD_HI): bus_rdata <= prd_q[1];
        AW'(OFF_CTRL):   bus_rdata <= ctrl_word;
        AW'(OFF_GCTRL):  bus_rdata <= gctrl_word;
        default:         bus_rdata <= '0;
      endcase
    end
  end

  assign en    = en_q;
  assign gmode = gm_q;
  assign rel   = rel_q;
  assign prd   = prd_q;
endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
  import dht_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int LO_POS = 6,
  parameter int HI_POS = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          evt_lo,
  output logic          evt_hi
);
  localparam int NH = 2;

  logic [NH-1:0][1:0]    en_w;
  logic [1:0]            gmode_w;
  logic [NH-1:0]         rel_w;
  logic [NH-1:0][DW-1:0] prd_w;
  logic [NH-1:0][DW-1:0] cnt_w;
  logic [NH-1:0]         wr_cnt_w;
  logic [NH-1:0]         eq_w;
  logic [NH-1:0]         hold_w;
  logic [NH-1:0]         step_w;
  logic [NH-1:0]         wrap_w;
  logic [NH-1:0]         hit_w;
  logic [NH-1:0]         evt_w;

  dht_regs #(
    .DW(DW), .AW(AW), .NH(NH), .LO_POS(LO_POS), .HI_POS(HI_POS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt      (cnt_w),
    .done     (hit_w),
    .bus_rdata(bus_rdata),
    .en       (en_w),
    .gmode    (gmode_w),
    .rel      (rel_w),
    .prd      (prd_w),
    .wr_cnt   (wr_cnt_w)
  );

  dht_seq #(.DW(DW), .NH(NH)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .gmode (gmode_w),
    .en    (en_w),
    .rel   (rel_w),
    .eq    (eq_w),
    .cnt_lo(cnt_w[0]),
    .hold  (hold_w),
    .step  (step_w),
    .wrap  (wrap_w),
    .hit   (hit_w),
    .evt   (evt_w)
  );

  generate
    for (genvar h = 0; h < NH; h++) begin : g_half
      dht_half #(.DW(DW)) u_half (
        .clk  (clk),
        .rst  (rst),
        .hold (hold_w[h]),
        .wr   (wr_cnt_w[h]),
        .wdata(bus_wdata),
        .step (step_w[h]),
        .wrap (wrap_w[h]),
        .prd  (prd_w[h]),
        .cnt  (cnt_w[h]),
        .eq   (eq_w[h])
      );
    end
  endgenerate

  assign evt_lo = evt_w[0];
  assign evt_hi = evt_w[1];
endmodule

// File: rtl/dht_checker.sv
module dht_checker
  import dht_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          evt_lo,
  input logic          evt_hi,
  input logic [1:0]    en_lo,
  input logic          rel_lo,
  input logic [1:0]    gmode,
  input logic [DW-1:0] cnt_lo,
  input logic          hit_lo
);
  logic ctrl_wr;
  logic cnt_lo_wr;

  assign ctrl_wr   = bus_wr && (bus_addr == AW'(OFF_CTRL));
  assign cnt_lo_wr = bus_wr && (bus_addr == AW'(OFF_CNT_LO));

  // R4: unreleased lower half is zero on the next cycle
  a_r4_hold_zero: assert property (@(posedge clk) disable iff (rst)
    !rel_lo |=> (cnt_lo == '0));

  // R7: single-shot finish clears the lower enable field
  a_r7_once_clears: assert property (@(posedge clk) disable iff (rst)
    (en_lo == EN_ONCE && hit_lo && !ctrl_wr) |=> (en_lo == EN_OFF));

  // R9: linked mode never pulses the upper event
  a_r9_hi_quiet: assert property (@(posedge clk) disable iff (rst)
    (gmode == GM_LINK64 && $past(gmode) == GM_LINK64) |-> !evt_hi);

  // R6: a lower event needs a running, released half the cycle before
  a_r6_evt_needs_run: assert property (@(posedge clk) disable iff (rst)
    evt_lo |-> $past(en_runs(en_lo) && rel_lo));

  // R3: enable value 3 freezes the count in split mode
  a_r3_rsvd_frozen: assert property (@(posedge clk) disable iff (rst)
    (en_lo == 2'd3 && gmode != GM_LINK64 && rel_lo && !cnt_lo_wr) |=> $stable(cnt_lo));

  // R11: a count write on a released half always lands
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    (cnt_lo_wr && rel_lo) |=> (cnt_lo == $past(bus_wdata)));
endmodule

bind dual_half_timer dht_checker #(.DW(DW), .AW(AW)) u_dht_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .evt_lo   (evt_lo),
  .evt_hi   (evt_hi),
  .en_lo    (en_w[0]),
  .rel_lo   (rel_w[0]),
  .gmode    (gmode_w),
  .cnt_lo   (cnt_w[0]),
  .hit_lo   (hit_w[0])
);

// File: tb/dual_half_timer_bench.sv
module dual_half_timer_bench;
  localparam logic [7:0] A_ID = 8'h00, A_CLO = 8'h10, A_CHI = 8'h14,
                         A_PLO = 8'h18, A_PHI = 8'h1C, A_CTL = 8'h20,
                         A_GCT = 8'h24, A_WDG = 8'h28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_lo, evt_hi;

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  dual_half_timer u_dual_half_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_lo(evt_lo), .evt_hi(evt_hi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // R1 R2: reset values and identity
  task automatic t_reset();
    logic [31:0] d;
    check("R1 evt_lo after reset", 32'(evt_lo), 0);
    check("R1 evt_hi after reset", 32'(evt_hi), 0);
    rd(A_ID, d);  check("R1 id word", d, 32'h7D4E_0001);
    rd(A_CTL, d); check("R1 ctrl reset", d, 0);
    rd(A_GCT, d); check("R1 gctrl reset", d, 0);
    rd(A_CLO, d); check("R1 cnt_lo reset", d, 0);
    rd(A_PHI, d); check("R1 prd_hi reset", d, 0);
    wr(A_PLO, 32'hA5A5_0001); wr(A_PHI, 32'h0000_BEEF);
    rd(A_PLO, d); check("R2 prd_lo readback", d, 32'hA5A5_0001);
    rd(A_PHI, d); check("R2 prd_hi readback", d, 32'h0000_BEEF);
  endtask

  // R4: unreleased half stays at zero
  task automatic t_hold();
    logic [31:0] d;
    int bad = 0;
    wr(A_GCT, 32'h4);
    wr(A_PLO, 32'd1);
    wr(A_CTL, 32'(2) << 6);
    wr(A_CLO, 32'd5);
    rd(A_CLO, d); check("R4 count write ignored while held", d, 0);
    for (int k = 0; k < 6; k++) begin tick(); if (evt_lo) bad++; end
    check("R4 no event while held", 32'(bad), 0);
    wr(A_CTL, 0);
    wr(A_GCT, 32'h7);
  endtask

  // R5: writes to an idle half
  task automatic t_idle_write();
    logic [31:0] d;
    wr(A_CLO, 32'h1234);
    rd(A_CLO, d); check("R5 idle write visible", d, 32'h1234);
    repeat (5) tick();
    rd(A_CLO, d); check("R5 idle count unchanged", d, 32'h1234);
    wr(A_CLO, 0);
    rd(A_CLO, d); check("R5 zero write", d, 0);
  endtask

  // R6: repeating lower half with period 3
  task automatic t_repeat();
    int bad = 0;
    wr(A_CLO, 0); wr(A_PLO, 32'd3);
    wr(A_CTL, 32'(2) << 6);
    for (int k = 1; k <= 12; k++) begin
      tick();
      if (evt_lo !== ((k % 4) == 0)) bad++;
    end
    check("R6 pulse every period+1", 32'(bad), 0);
    wr(A_CTL, 0);
  endtask

  // R7: single-shot upper half with period 2
  task automatic t_once();
    logic [31:0] d;
    int bad = 0;
    wr(A_CHI, 0); wr(A_PHI, 32'd2);
    wr(A_CTL, 32'(1) << 22);
    for (int k = 1; k <= 10; k++) begin
      tick();
      if (evt_hi !== (k == 3)) bad++;
    end
    check("R7 single pulse", 32'(bad), 0);
    rd(A_CTL, d); check("R7 field cleared", d, 0);
    rd(A_CHI, d); check("R7 count back at zero", d, 0);
  endtask

  // R8: both halves, different periods
  task automatic t_split();
    int bad = 0;
    wr(A_CLO, 0); wr(A_CHI, 0);
    wr(A_PLO, 32'd1); wr(A_PHI, 32'd4);
    wr(A_CTL, (32'(2) << 6) | (32'(2) << 22));
    for (int k = 1; k <= 20; k++) begin
      tick();
      if (evt_lo !== ((k % 2) == 0)) bad++;
      if (evt_hi !== ((k % 5) == 0)) bad++;
    end
    check("R8 independent halves", 32'(bad), 0);
    wr(A_CTL, 0);
  endtask

  // R3 R10: reserved encodings and bits
  task automatic t_reserved();
    logic [31:0] d;
    int bad = 0;
    wr(A_CLO, 32'd7);
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, d); check("R10 ctrl reserved bits zero", d, 32'h00C0_00C0);
    for (int k = 0; k < 4; k++) begin tick(); if (evt_lo || evt_hi) bad++; end
    check("R3 field 3 raises no event", 32'(bad), 0);
    rd(A_CLO, d); check("R3 field 3 does not count", d, 32'd7);
    wr(A_CTL, 0);
    wr(A_GCT, 32'hFFFF_FFFF);
    rd(A_GCT, d); check("R10 gctrl reserved bits zero", d, 32'hF);
    wr(A_GCT, 32'h7);
    wr(A_WDG, 32'hFFFF_FFFF);
    rd(A_WDG, d); check("R10 offset 0x28 reads zero", d, 0);
    rd(A_CLO, d); check("R10 stray write no effect", d, 32'd7);
  endtask

  // R9: linked 64-bit single shot across the lower rollover
  task automatic t_linked();
    logic [31:0] d;
    int bad = 0;
    wr(A_GCT, 32'h3);
    wr(A_CLO, 32'hFFFF_FFFE); wr(A_CHI, 0);
    wr(A_PLO, 32'd2); wr(A_PHI, 32'd1);
    wr(A_CTL, 32'(1) << 6);
    for (int k = 1; k <= 8; k++) begin
      tick();
      if (evt_lo !== (k == 5)) bad++;
      if (evt_hi !== 1'b0) bad++;
    end
    check("R9 64-bit match timing", 32'(bad), 0);
    rd(A_CTL, d); check("R9 lower field cleared", d, 0);
    rd(A_CHI, d); check("R9 upper back at zero", d, 0);
    wr(A_GCT, 32'h7);
  endtask

  // R11: bus write landing on the match edge
  task automatic t_collide();
    logic [31:0] d;
    wr(A_CLO, 0); wr(A_PLO, 32'd3);
    wr(A_CTL, 32'(2) << 6);
    repeat (3) tick();
    wr(A_CLO, 32'h10);
    check("R11 event kept on count write", 32'(evt_lo), 1);
    wr(A_CTL, 0);
    rd(A_CLO, d); check("R11 written count wins", d, 32'h11);
    wr(A_CLO, 0); wr(A_PLO, 32'd2);
    wr(A_CTL, 32'(1) << 6);
    repeat (2) tick();
    wr(A_CTL, 32'(2) << 6);
    check("R11 event on single-shot finish", 32'(evt_lo), 1);
    repeat (3) tick();
    check("R11 repeat mode survives clear", 32'(evt_lo), 1);
    rd(A_CTL, d); check("R11 ctrl holds written mode", d, 32'h80);
    wr(A_CTL, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hold();
    t_idle_write();
    t_repeat();
    t_once();
    t_split();
    t_reserved();
    t_linked();
    t_collide();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule